// File: doc/BRIEF.md
# Three-Channel Serial Converter Result Reader

This block collects results from three 16-bit successive-approximation converters that convert in parallel. The converters share one serial clock, which this block generates, and each converter has its own serial data line and its own active-low end-of-conversion line. Chip select is not an output of the block: it is held active on the board. Both inputs of every channel arrive through optical isolators, so each is re-timed by a two-flop synchronizer before any decision is made on it.

A word starts when a channel's end-of-conversion line is seen going from high to low at a sample point. The block then shifts 16 bits in, most significant bit first, one per serial clock period. When the last bit is in, the channel's output word is replaced and a one-cycle valid pulse is raised. If end-of-conversion goes high again before all 16 bits have arrived, the partial word is dropped. The previously completed word stays on the output until a complete new one replaces it, so a sampler never sees a half-shifted value. The three channels are framed independently but move in lockstep on the shared clock.

Top module: `adc_eoc_reader`

## Requirements
- R1: While rst_ni is low and right after its release, every output word is 0, every valid bit is 0 and sclk_o is low.
- R2: sclk_o is a free-running square wave that stays high for HALF_DIV system clock cycles and then low for HALF_DIV cycles (8-cycle period with the default HALF_DIV = 4).
- R3: A word is captured only after the synchronized end-of-conversion line (eoc_ni, low = result ready) is seen high at one sample point and low at the next. A line that is already low when reset is released starts no capture.
- R4: A sample point is the last system cycle of the sclk_o high phase. The converter changes its data on the sclk_o falling edge. The bit sampled at the first sample point with end-of-conversion low is the word's bit 15, and the next 15 sample points give bits 14 down to 0.
- R5: After the 16th bit is taken, the channel's valid bit is high for exactly one system cycle, and in that same cycle its word slice word_o[16*c +: 16] holds the new value.
- R6: A channel's word slice changes only in a cycle in which that channel's valid bit is high. During a frame it keeps showing the previous complete word.
- R7: If end-of-conversion returns high before 16 bits have been sampled, the frame is abandoned. No valid pulse follows and the word slice keeps its old value.
- R8: The channels are independent. Different words, or an abandoned frame on one channel, leave the result and the pulses of every other channel unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| eoc_ni | input | N_CH | Per-channel end-of-conversion, active low, asynchronous |
| sdata_i | input | N_CH | Per-channel serial result data, asynchronous |
| sclk_o | output | 1 | Serial clock shared by all converters |
| word_o | output | N_CH*WIDTH | Latest complete word per channel, channel c at [WIDTH*c +: WIDTH] |
| valid_o | output | N_CH | One-cycle pulse per channel when its word is updated |

## Verification
The bench sweeps a walking one, a walking zero and arithmetic patterns through the three channels at once, so a reversed bit order or an off-by-one bit count shows up as a wrong word. It holds end-of-conversion low out of reset while toggling the data. A reader that took a low level as a start, instead of a high-to-low change, would then produce spurious words. Frames are cut short at several bit positions on one channel at a time. A design that did not abandon a cut frame would pulse or publish garbage there, and a design that shared frame state would disturb the other channels. Part way through each frame the bench reads the outputs back to catch any shift register that leaks onto the output word, and the pulse monitor flags any valid pulse longer than one cycle.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int unsigned N_CH_DEF  = 3;
  localparam int unsigned WIDTH_DEF = 16;
  localparam int unsigned HALF_DEF  = 4;
endpackage

// File: rtl/adc_sync2.sv
module adc_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] rst_val_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= rst_val_i;
      sync_q <= rst_val_i;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic sclk_o,
  output logic smp_o
);
  localparam int unsigned CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // sample on last cycle of the high phase
  assign smp_o  = sclk_q && (cnt_q == LAST);
  assign sclk_o = sclk_q;

  a_r2_phase_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != LAST) |=> $stable(sclk_q));
endmodule

// File: rtl/adc_chan_rx.sv
module adc_chan_rx #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_i,
  input  logic             eoc_n_i,
  input  logic             dat_i,
  output logic [WIDTH-1:0] word_o,
  output logic             valid_o
);
  localparam int unsigned BW = $clog2(WIDTH + 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(WIDTH - 1);

  logic             busy_q, eoc_prev_q, valid_q;
  logic [BW-1:0]    bit_q;
  logic [WIDTH-1:0] shr_q, word_q;
  logic [WIDTH-1:0] shr_nxt;

  assign shr_nxt = {shr_q[WIDTH-2:0], dat_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      eoc_prev_q <= 1'b0; // low at reset: a held-low line cannot start a frame
      valid_q    <= 1'b0;
      bit_q      <= '0;
      shr_q      <= '0;
      word_q     <= '0;
    end else begin
      valid_q <= 1'b0;
      if (smp_i) begin
        eoc_prev_q <= eoc_n_i;
        if (eoc_n_i) begin
          busy_q <= 1'b0;       // abandon any partial frame
        end else if (busy_q) begin
          shr_q <= shr_nxt;
          bit_q <= bit_q + 1'b1;
          if (bit_q == LAST_BIT) begin
            busy_q  <= 1'b0;
            word_q  <= shr_nxt;
            valid_q <= 1'b1;
          end
        end else if (eoc_prev_q) begin
          busy_q <= 1'b1;
          shr_q  <= shr_nxt;
          bit_q  <= BW'(1);
        end
      end
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;

  a_r4_bit_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (bit_q <= LAST_BIT));
  a_r5_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  a_r6_word_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(word_q) |-> valid_q);
  a_r7_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_i && eoc_n_i) |=> (!busy_q && !valid_q));
  a_r3_start_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(eoc_prev_q));
endmodule

// File: rtl/adc_eoc_reader.sv
module adc_eoc_reader
  import adc_rd_pkg::*;
#(
  parameter int unsigned N_CH     = N_CH_DEF,
  parameter int unsigned WIDTH    = WIDTH_DEF,
  parameter int unsigned HALF_DIV = HALF_DEF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_CH-1:0]       eoc_ni,
  input  logic [N_CH-1:0]       sdata_i,
  output logic                  sclk_o,
  output logic [N_CH*WIDTH-1:0] word_o,
  output logic [N_CH-1:0]       valid_o
);
  localparam int unsigned SW = 2 * N_CH;

  logic [SW-1:0]   sync_d, sync_q;
  logic [N_CH-1:0] eoc_s, dat_s;
  logic            smp;

  assign sync_d = {eoc_ni, sdata_i};

  adc_sync2 #(.W(SW)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .d_i       (sync_d),
    .rst_val_i ({{N_CH{1'b1}}, {N_CH{1'b0}}}),
    .q_o       (sync_q)
  );

  assign eoc_s = sync_q[SW-1:N_CH];
  assign dat_s = sync_q[N_CH-1:0];

  adc_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_o (sclk_o),
    .smp_o  (smp)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    adc_chan_rx #(.WIDTH(WIDTH)) u_rx (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .smp_i   (smp),
      .eoc_n_i (eoc_s[c]),
      .dat_i   (dat_s[c]),
      .word_o  (word_o[c*WIDTH +: WIDTH]),
      .valid_o (valid_o[c])
    );
  end

  a_r5_valid_on_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|valid_o) |-> $past(smp));
endmodule

// File: tb/adc_eoc_reader_test.sv
`timescale 1ns/1ps
module adc_eoc_reader_test;
  localparam int NC = 3;
  localparam int W  = 16;
  localparam int HD = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] eoc_n = '0;
  logic [NC-1:0] sd = '0;
  logic          sclk;
  logic [NC*W-1:0] word;
  logic [NC-1:0] valid;

  int total = 0, bad = 0;
  int pc[NC];
  logic [W-1:0] exp_w[NC];
  bit dbl[NC];
  logic [NC-1:0] valid_prev = '0;

  always #2.5 clk = ~clk;

  adc_eoc_reader #(.N_CH(NC), .WIDTH(W), .HALF_DIV(HD)) uut (
    .clk_i(clk), .rst_ni(rst_n), .eoc_ni(eoc_n), .sdata_i(sd),
    .sclk_o(sclk), .word_o(word), .valid_o(valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // pulse monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NC; c++) begin
        if (valid[c]) pc[c]++;
        if (valid[c] && valid_prev[c]) dbl[c] = 1'b1;
      end
      valid_prev = valid;
    end
  end

  task automatic fall_edge();
    @(negedge sclk);
    #1;
  endtask

  task automatic frame(input logic [W-1:0] w0, input logic [W-1:0] w1,
                       input logic [W-1:0] w2, input int a0, input int a1,
                       input int a2, input string tag);
    logic [W-1:0] w[NC];
    int ab[NC];
    int p0[NC];
    w[0] = w0; w[1] = w1; w[2] = w2;
    ab[0] = a0; ab[1] = a1; ab[2] = a2;
    for (int c = 0; c < NC; c++) p0[c] = pc[c];
    repeat (2) begin
      fall_edge();
      eoc_n = '1;
      sd = ~sd;
    end
    for (int b = 0; b < W; b++) begin
      fall_edge();
      for (int c = 0; c < NC; c++) begin
        if (b < ab[c]) begin
          eoc_n[c] = 1'b0;
          sd[c] = w[c][W-1-b];
        end else begin
          eoc_n[c] = 1'b1;
          sd[c] = ~sd[c];
        end
      end
      if (b == 8) begin
        @(negedge clk);
        for (int c = 0; c < NC; c++)
          chk(word[c*W +: W] == exp_w[c], {"R6 hold mid-frame ", tag},
              int'(word[c*W +: W]), int'(exp_w[c]));
      end
    end
    fall_edge();
    eoc_n = '1;
    repeat (2) fall_edge();
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      if (ab[c] >= W) begin
        exp_w[c] = w[c];
        chk(pc[c] - p0[c] == 1, {"R5 one pulse ", tag}, pc[c] - p0[c], 1);
        chk(word[c*W +: W] == exp_w[c], {"R4 R8 word ", tag},
            int'(word[c*W +: W]), int'(exp_w[c]));
      end else begin
        chk(pc[c] - p0[c] == 0, {"R7 no pulse on abort ", tag}, pc[c] - p0[c], 0);
        chk(word[c*W +: W] == exp_w[c], {"R7 R8 word kept ", tag},
            int'(word[c*W +: W]), int'(exp_w[c]));
      end
    end
  endtask

  initial begin
    for (int c = 0; c < NC; c++) begin
      pc[c] = 0; exp_w[c] = '0; dbl[c] = 1'b0;
    end
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(word == '0, "R1 word in reset", int'(word[31:0]), 0);
    chk(valid == '0, "R1 valid in reset", int'(valid), 0);
    chk(sclk == 1'b0, "R1 sclk in reset", int'(sclk), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(word == '0 && valid == '0 && sclk == 1'b0, "R1 after release",
        int'(word[31:0]), 0);

    // R2: period and high time
    begin
      int hi, per;
      @(posedge sclk); @(negedge clk);
      hi = 0; per = 0;
      while (sclk) begin hi++; per++; @(negedge clk); end
      while (!sclk) begin per++; @(negedge clk); end
      chk(hi == HD, "R2 high phase", hi, HD);
      chk(per == 2 * HD, "R2 period", per, 2 * HD);
    end

    // R3: eoc held low from reset with toggling data, no capture
    for (int i = 0; i < 40; i++) begin
      fall_edge();
      sd = sd + 3'd1;
    end
    @(negedge clk);
    for (int c = 0; c < NC; c++)
      chk(pc[c] == 0 && word[c*W +: W] == '0, "R3 low at reset no start",
          pc[c], 0);

    // sweeps
    for (int k = 0; k < W; k++)
      frame(W'(1) << k, ~(W'(1) << k), W'(k * 16'h0F1D + 16'h03A5), W, W, W,
            "R4 walk");
    frame(16'h0000, 16'hFFFF, 16'hAAAA, W, W, W, "R4 edge");
    frame(16'hFFFF, 16'h0000, 16'h5555, W, W, W, "R4 edge2");
    frame(16'h8001, 16'h7FFE, 16'hC33C, W, W, W, "R4 ends");
    for (int k = 0; k < 6; k++) begin
      int a;
      a = 2 + k * 3;
      if (a >= W) a = W - 1;
      case (k % 3)
        0: frame(16'h1357, 16'h2468, 16'h9ABC, a, W, W, "R7 ch0 cut");
        1: frame(16'hDEAD, 16'hBEEF, 16'hF00D, W, a, W, "R7 ch1 cut");
        default: frame(16'h0F0F, 16'hF0F0, 16'h3C3C, W, W, a, "R7 ch2 cut");
      endcase
    end
    frame(16'h4321, 16'h8765, 16'hCBA9, W, W, W, "R8 after cuts");

    for (int c = 0; c < NC; c++)
      chk(!dbl[c], "R5 single-cycle pulse", int'(dbl[c]), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #900000;
    total++;
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule